// File: doc/BRIEF.md
# Multichannel Delay-and-Sum Dedisperser

This block turns a stream of complex filterbank samples into a single dedispersed power series for one trial dispersion value. Samples arrive one channel per beat over a valid/ready handshake, a frame being one sample for each of `2*NUM_CH` channels in fixed order. Only the first `NUM_CH` channels of each frame carry unique spectrum. The block squares and adds I and Q to get a power per sample. It averages `DECIM` consecutive frames per channel, and it delays each channel's averaged power by its own programmed count of averaged frames. It then adds the aligned powers of all used channels into one output word per averaged frame.

A dispersed pulse reaches low-frequency channels later than high-frequency ones. Channels at lower frequency are therefore given smaller delays, so that the early high-frequency copy waits for the late low-frequency copy. The reference channel carries a delay of zero, and any channel may serve as the reference. Delays are computed elsewhere and written into a per-channel table while the block is idle (`run` low). Raising `run` restarts frame alignment and the delay-line fill. Output backpressure stalls the input through `in_ready`.

Top module: `dedisp_sum`

## Requirements
- R1: A sample's power is I*I + Q*Q, with I and Q as two's-complement `SW`-bit values. The output adds powers, never the complex values.
- R2: For each used channel, `DECIM` (default 8) consecutive frames of power are added and divided by `DECIM`, rounding down. Averaged frame k covers input frames k*DECIM to k*DECIM+DECIM-1, counted from the start of the run.
- R3: Within each frame, beats with channel index `NUM_CH` to `2*NUM_CH-1` (the last half, index counted from 0 at the first beat of the frame) have no effect on the output.
- R4: Output for averaged frame k is the sum over used channels c of channel c's averaged frame k-d[c], where d[c] is the table entry for c. An entry of 0 means the channel's current averaged frame is used undelayed (the reference).
- R5: After `run` rises, the first output belongs to averaged frame `MAX_DELAY`. After that, exactly one output is produced per averaged frame, in order.
- R6: The output is `2*SW+$clog2(NUM_CH)` bits wide and holds `NUM_CH` times the largest power (all inputs -2^(SW-1)) without wrapping.
- R7: A write on `tbl_we` updates entry `tbl_addr` only while `run` is low. A write while `run` is high is ignored.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_sum` holds. No output is lost or repeated.
- R9: After reset, `out_valid` and `in_ready` are low. `in_ready` stays low while `run` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High to process; rising edge restarts alignment; low allows table writes |
| tbl_we | input | 1 | Delay table write strobe |
| tbl_addr | input | $clog2(NUM_CH) | Channel whose delay is written |
| tbl_delay | input | $clog2(MAX_DELAY+1) | Delay in averaged frames |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_i | input | SW | In-phase part, signed |
| in_q | input | SW | Quadrature part, signed |
| out_valid | output | 1 | Output sum valid |
| out_ready | input | 1 | Downstream accepts the sum |
| out_sum | output | 2*SW+$clog2(NUM_CH) | Dedispersed power sum |

## Verification
The bench targets delay extremes: zero, where a design that reads the line before writing it would return a stale frame, and the maximum, where an off-by-one read pointer would pick a sample one frame too young. Full-scale negative inputs expose an accumulator that wraps or a squarer that loses the sign. Large values on the unused upper-half channels show up at once in a design that sums them. Irregular output stalls reveal lost or doubled sums. A table write made mid-run must leave the sums untouched, or it would show that idle gating is missing.

// File: rtl/dd_pkg.sv
package dd_pkg;
    // Index of the ring slot that lies `back` places behind `head`, in a ring of `depth` slots.
    function automatic int ring_back(int head, int back, int depth);
        return (head >= back) ? head - back : head + depth - back;
    endfunction
endpackage

// File: rtl/dd_power.sv
// dd_power: detects one complex sample as I*I + Q*Q.
// Assumes I and Q are signed SW-bit values; the result is unsigned, 2*SW bits,
// and fits because the largest value is 2^(2*SW-1).
module dd_power #(
    parameter int SW = 8,
    localparam int PW = 2 * SW
) (
    input  logic [SW-1:0] in_i,
    input  logic [SW-1:0] in_q,
    output logic [PW-1:0] pwr
);
    logic signed [PW:0] ext_i, ext_q, sq_sum;

    // Sign-extend, square and add in one extra bit of headroom.
    always_comb begin
        ext_i  = {{(SW+1){in_i[SW-1]}}, in_i};
        ext_q  = {{(SW+1){in_q[SW-1]}}, in_q};
        sq_sum = ext_i * ext_i + ext_q * ext_q;
        pwr    = sq_sum[PW-1:0];
    end
endmodule

// File: rtl/dd_decim.sv
// dd_decim: per-channel frame averager.
// Adds DECIM powers per channel and presents the floor of their mean on the last one.
// Assumes DECIM is a power of two (at least 2) and that `first` marks frame 0 of a group.
module dd_decim #(
    parameter int NUM_CH = 4,
    parameter int PW = 16,
    parameter int DECIM = 8,
    localparam int CH_W = $clog2(NUM_CH),
    localparam int LOG = $clog2(DECIM),
    localparam int AW = PW + LOG
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            en,
    input  logic [CH_W-1:0] ch,
    input  logic            first,
    input  logic [PW-1:0]   pwr,
    output logic [PW-1:0]   avg_o
);
    localparam logic [PW-1:0] PMAX = {1'b1, {(PW-1){1'b0}}};

    logic [AW-1:0] acc [NUM_CH];
    logic [AW-1:0] tot;
    logic [AW-1:0] shifted;

    // Running total for the current channel and its mean.
    always_comb begin
        tot     = (first ? '0 : acc[ch]) + AW'(pwr);
        shifted = tot >> LOG;
        avg_o   = shifted[PW-1:0];
    end

    // Store the running total for the channel on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int c = 0; c < NUM_CH; c++) acc[c] <= '0;
        end else if (en) begin
            acc[ch] <= tot;
        end
    end

    // The mean of powers can never exceed one full-scale power.
    assert_avg_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> avg_o <= PMAX);
endmodule

// File: rtl/dd_delay_bank.sv
// dd_delay_bank: one circular line of MAX_DELAY+1 averaged powers per channel.
// The shared write slot advances once per averaged frame (driven by the parent).
// A read looks `dly` slots behind it; a zero delay forwards the incoming word.
module dd_delay_bank #(
    parameter int NUM_CH = 4,
    parameter int PW = 16,
    parameter int MAX_DELAY = 7,
    localparam int CH_W = $clog2(NUM_CH),
    localparam int DEPTH = MAX_DELAY + 1,
    localparam int DLY_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [CH_W-1:0]  ch,
    input  logic [DLY_W-1:0] wptr,
    input  logic [DLY_W-1:0] dly,
    input  logic [PW-1:0]    din,
    output logic [PW-1:0]    dout
);
    logic [DLY_W-1:0] rd_slot;
    logic [PW-1:0]    rd_word [NUM_CH];

    // Slot holding the word written `dly` frames ago.
    always_comb rd_slot = DLY_W'(dd_pkg::ring_back(int'(wptr), int'(dly), DEPTH));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_line
        logic [PW-1:0] line [DEPTH];

        // Write the newest averaged power of channel g; clear on restart.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                for (int s = 0; s < DEPTH; s++) line[s] <= '0;
            end else if (we && ch == CH_W'(g)) begin
                line[wptr] <= din;
            end
        end

        assign rd_word[g] = line[rd_slot];
    end

    // Zero delay bypasses the line so the reference channel is not aged.
    always_comb dout = (dly == '0) ? din : rd_word[ch];
endmodule

// File: rtl/dedisp_sum.sv
// dedisp_sum: delay-and-sum dedisperser for one trial dispersion value.
// Takes one channel sample per beat, frames of 2*NUM_CH beats of which the first NUM_CH count.
// Detects, averages DECIM frames, delays each channel by its table entry and sums.
// Assumes NUM_CH and DECIM are powers of two and DECIM >= 2.
module dedisp_sum #(
    parameter int NUM_CH = 4,
    parameter int SW = 8,
    parameter int DECIM = 8,
    parameter int MAX_DELAY = 7,
    localparam int IN_CH = 2 * NUM_CH,
    localparam int CH_W = $clog2(NUM_CH),
    localparam int IC_W = $clog2(IN_CH),
    localparam int DC_W = $clog2(DECIM),
    localparam int DLY_W = $clog2(MAX_DELAY + 1),
    localparam int PW = 2 * SW,
    localparam int SUM_W = PW + $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tbl_we,
    input  logic [CH_W-1:0]  tbl_addr,
    input  logic [DLY_W-1:0] tbl_delay,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SW-1:0]    in_i,
    input  logic [SW-1:0]    in_q,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [SUM_W-1:0] out_sum
);
    localparam logic [SUM_W-1:0] SUM_CAP = SUM_W'(NUM_CH) << (PW - 1);

    logic             run_q, start, beat, used, first, last;
    logic             dec_en, line_we, emit;
    logic [IC_W-1:0]  ch_cnt;
    logic [CH_W-1:0]  ch_lo;
    logic [DC_W-1:0]  dec_cnt;
    logic [DLY_W-1:0] wptr, fill;
    logic [DLY_W-1:0] dly_tbl [NUM_CH];
    logic [PW-1:0]    pwr, avg, dly_out;
    logic [SUM_W-1:0] sum_acc, partial, tot;

    // Handshake and beat qualification.
    always_comb begin
        start    = run && !run_q;
        in_ready = run && run_q && !(out_valid && !out_ready);
        beat     = in_valid && in_ready;
        used     = ch_cnt < IC_W'(NUM_CH);
        ch_lo    = ch_cnt[CH_W-1:0];
        first    = dec_cnt == '0;
        last     = dec_cnt == DC_W'(DECIM - 1);
        dec_en   = beat && used;
        line_we  = dec_en && last;
        emit     = line_we && ch_cnt == IC_W'(NUM_CH - 1) && fill == DLY_W'(MAX_DELAY);
        partial  = (ch_cnt == '0) ? '0 : sum_acc;
        tot      = partial + SUM_W'(dly_out);
    end

    dd_power #(.SW(SW)) i_power (.in_i(in_i), .in_q(in_q), .pwr(pwr));

    dd_decim #(.NUM_CH(NUM_CH), .PW(PW), .DECIM(DECIM)) i_decim (
        .clk(clk), .rst_n(rst_n), .clr(start), .en(dec_en), .ch(ch_lo),
        .first(first), .pwr(pwr), .avg_o(avg));

    dd_delay_bank #(.NUM_CH(NUM_CH), .PW(PW), .MAX_DELAY(MAX_DELAY)) i_bank (
        .clk(clk), .rst_n(rst_n), .clr(start), .we(line_we), .ch(ch_lo),
        .wptr(wptr), .dly(dly_tbl[ch_lo]), .din(avg), .dout(dly_out));

    // Remember run to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run;
    end

    // Delay table: writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) dly_tbl[c] <= '0;
        end else if (tbl_we && !run) begin
            dly_tbl[tbl_addr] <= tbl_delay;
        end
    end

    // Channel, averaging and ring position counters plus the partial sum.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            ch_cnt  <= '0;
            dec_cnt <= '0;
            wptr    <= '0;
            fill    <= '0;
            sum_acc <= '0;
        end else if (beat) begin
            if (line_we) sum_acc <= tot;
            if (ch_cnt == IC_W'(IN_CH - 1)) begin
                ch_cnt  <= '0;
                dec_cnt <= last ? '0 : dec_cnt + 1'b1;
                if (last) begin
                    wptr <= (wptr == DLY_W'(MAX_DELAY)) ? '0 : wptr + 1'b1;
                    if (fill != DLY_W'(MAX_DELAY)) fill <= fill + 1'b1;
                end
            end else begin
                ch_cnt <= ch_cnt + 1'b1;
            end
        end
    end

    // Output register with hold under backpressure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sum   <= '0;
        end else if (!run) begin
            out_valid <= 1'b0;
        end else if (emit) begin
            out_valid <= 1'b1;
            out_sum   <= tot;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && run |=> out_valid && $stable(out_sum));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_sum <= SUM_CAP);

    assert_first_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> fill == DLY_W'(MAX_DELAY));
endmodule

// File: tb/test_dedisp_sum.sv
module test_dedisp_sum;
    localparam int NCH = 4, ICH = 8, DEC = 8, MAXD = 7, NDEC = 12;

    // Scenario fields: [22] table write mid-run, [21] output stalls, [20] full-scale input,
    // [19:12] pattern seed, [11:0] delays d3..d0 (3 bits each, d0 lowest).
    localparam logic [22:0] SCN [6] = '{
        {1'b0, 1'b0, 1'b0, 8'd1, 3'd0, 3'd0, 3'd0, 3'd0},
        {1'b0, 1'b0, 1'b0, 8'd2, 3'd0, 3'd2, 3'd5, 3'd7},
        {1'b0, 1'b1, 1'b0, 8'd3, 3'd7, 3'd7, 3'd7, 3'd7},
        {1'b1, 1'b0, 1'b0, 8'd4, 3'd7, 3'd5, 3'd3, 3'd1},
        {1'b0, 1'b0, 1'b1, 8'd0, 3'd3, 3'd2, 3'd1, 3'd0},
        {1'b0, 1'b1, 1'b0, 8'd9, 3'd2, 3'd6, 3'd0, 3'd3}
    };

    logic clk = 0, rst_n = 0, run = 0, tbl_we = 0, in_valid = 0, out_ready = 0;
    logic [1:0] tbl_addr = '0;
    logic [2:0] tbl_delay = '0;
    logic [7:0] in_i = '0, in_q = '0;
    logic in_ready, out_valid;
    logic [17:0] out_sum;
    int total = 0, bad = 0;

    dedisp_sum i_dedisp_sum (
        .clk(clk), .rst_n(rst_n), .run(run), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_delay(tbl_delay), .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i),
        .in_q(in_q), .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum));

    always #10 clk = ~clk;

    task automatic check(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pat(int seed, bit ext, int c, int t, bit isq);
        if (c >= NCH) return 127;          // unused half, must not reach the sum (R3)
        if (ext) return -128;
        if (isq) return ((seed * 3 + c * 11 + t * 9) % 23) - 11;
        return ((seed * 7 + c * 13 + t * 5) % 31) - 15;
    endfunction

    function automatic int avg_pw(int seed, bit ext, int c, int k);
        int s = 0;
        for (int j = 0; j < DEC; j++) begin
            int vi = pat(seed, ext, c, k * DEC + j, 1'b0);
            int vq = pat(seed, ext, c, k * DEC + j, 1'b1);
            s += vi * vi + vq * vq;
        end
        return s / DEC;
    endfunction

    function automatic int exp_sum(logic [22:0] sc, int k);
        int s = 0;
        for (int c = 0; c < NCH; c++)
            s += avg_pw(int'(sc[19:12]), sc[20], c, k - int'(sc[3*c +: 3]));
        return s;
    endfunction

    task automatic run_scn(int idx);
        logic [22:0] sc = SCN[idx];
        int b = 0, got = 0, cyc = 0, beats = NDEC * DEC * ICH;
        bit held = 0;
        logic [17:0] held_val = '0;
        @(negedge clk); run = 0;
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            @(negedge clk); tbl_we = 1; tbl_addr = 2'(c); tbl_delay = sc[3*c +: 3];
        end
        @(negedge clk); tbl_we = 0; run = 1;
        @(negedge clk);
        while ((b < beats || got < NDEC - MAXD) && cyc < beats * 4 + 100) begin
            @(negedge clk);
            cyc++;
            in_valid  = b < beats;
            in_i      = 8'(pat(int'(sc[19:12]), sc[20], b % ICH, b / ICH, 1'b0));
            in_q      = 8'(pat(int'(sc[19:12]), sc[20], b % ICH, b / ICH, 1'b1));
            out_ready = sc[21] ? (cyc % 3 != 0) : 1'b1;
            tbl_we    = sc[22] && b == 100;   // ignored while running (R7)
            tbl_addr  = 2'd0;
            tbl_delay = ~sc[2:0];
            #1;
            if (held) begin
                check("R8 held valid", out_valid, 1);
                check("R8 held sum", out_sum, held_val);
            end
            held = out_valid && !out_ready;
            held_val = out_sum;
            if (held) check("R8 stall in_ready", in_ready, 0);
            if (out_valid && out_ready) begin
                check($sformatf("R4/R5 scn%0d frame%0d", idx, MAXD + got), out_sum,
                      exp_sum(sc, MAXD + got));
                got++;
            end
            if (in_valid && in_ready) b++;
        end
        @(negedge clk); in_valid = 0; tbl_we = 0; out_ready = 1;
        repeat (3) @(negedge clk);
        check($sformatf("R5 output count scn%0d", idx), got, NDEC - MAXD);
        check("R5 no extra output", out_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset out_valid", out_valid, 0);
        check("R9 reset in_ready", in_ready, 0);
        rst_n = 1;
        @(negedge clk); in_valid = 1;
        #1 check("R9 idle in_ready", in_ready, 0);
        in_valid = 0;
        // Table vectors walked in order: R1 zero delays, R2 averaging, R3 unused half,
        // R4 mixed delays, R6 full scale, R7 mid-run write, R8 stalls.
        for (int s = 0; s < 6; s++) run_scn(s);
        // Restart with same delays: alignment and fill start over (R5).
        run_scn(1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule